// File: doc/BRIEF.md
# Target Presence Polling Sequencer

This block polls a target device on a two-wire serial bus until the target answers with an acknowledge. Host logic enables it by selecting controller (master) operation and turning on polling mode. A one-cycle strobe then marks a write of the target address, and the sequence begins. The sequencer asks a separate bit-level bus engine to send one address phase. It then waits for the engine to report whether the target acknowledged.

On a not-acknowledge the sequencer does not end the transfer with an error. It waits a programmable gap and tries again. The gap is counted in bus clock ticks, which the bit engine supplies as a one-cycle enable. When an attempt is acknowledged, the sequencer emits a single-cycle ready pulse. It then stays parked until polling mode is switched off.

Clearing either mode bit abandons the sequence at once, and no ready pulse follows. The bit-level engine is outside this block.

Top module: `smon_poll_seq`

## Requirements
- R1: After reset `attempt_req` and `slave_ready` are 0 and the block is idle.
- R2: The block acts only while both `ctrl_master` and `ctrl_monitor` are 1. An `addr_wr` strobe seen while either is 0 starts nothing: no `attempt_req` follows.
- R3: An `addr_wr` strobe in the idle state, with both mode bits set, makes `attempt_req` 1 for exactly one cycle, in the cycle after the strobe.
- R4: When `res_valid` is 1 with `res_ack` 1 while a result is awaited, `slave_ready` is 1 for exactly one cycle, in the next cycle.
- R5: When `res_valid` is 1 with `res_ack` 0 while a result is awaited, the next `attempt_req` comes in the cycle after the (`pause_len`+1)-th `bus_tick` following the result. `pause_len` is captured when the result arrives.
- R6: With `pause_len` = 0, the reset value, a single `bus_tick` after a not-acknowledge starts the next attempt.
- R7: The pause counts only cycles with `bus_tick` = 1. Any number of cycles without a tick does not advance it.
- R8: Clearing `ctrl_monitor` or `ctrl_master` in any state returns the block to idle. No `attempt_req` and no `slave_ready` follow, even if a result or ticks arrive afterwards.
- R9: After a ready pulse the block stays parked and ignores `addr_wr`, ticks and results until `ctrl_monitor` is cleared. After that, a new strobe with both bits set starts a fresh sequence.
- R10: `pause_len` is 4 bits wide, so gaps of 1 to 16 ticks are possible. The maximum value, 15, gives 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_master | input | 1 | Controller (master) operation selected |
| ctrl_monitor | input | 1 | Polling mode enabled |
| addr_wr | input | 1 | One-cycle strobe: target address written |
| pause_len | input | 4 | Inter-attempt gap, in bus ticks minus one |
| res_valid | input | 1 | Bit engine reports an address-phase result |
| res_ack | input | 1 | Result value: 1 acknowledged, 0 not acknowledged |
| bus_tick | input | 1 | One-cycle bus clock tick enable |
| attempt_req | output | 1 | One-cycle request to send an address phase |
| slave_ready | output | 1 | One-cycle pulse: target acknowledged |

## Verification
The in-RTL assertions check several rules on every cycle. Requests and ready pulses last one cycle. A dropped mode bit suppresses both outputs on the next cycle. The gap counter never counts up except at a load, and it never moves without a tick. The bench scenarios cover what a property cannot see in a single window: the exact number of ticks between a not-acknowledge and the retry for several pause values, the parked state after success, and the abort paths with late results.

// File: rtl/smon_pkg.sv
package smon_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ATTEMPT = 3'd1,
        ST_WAIT    = 3'd2,
        ST_PAUSE   = 3'd3,
        ST_DONE    = 3'd4
    } smon_state_e;

    typedef struct packed {
        smon_state_e state;
        logic        ready;
    } smon_ctl_s;
endpackage

// File: rtl/smon_gap_timer.sv
module smon_gap_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (tick_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R5
    no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> cnt_q <= $past(cnt_q));

    // R7
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/smon_poll_seq.sv
module smon_poll_seq
    import smon_pkg::*;
#(
    parameter int PAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_master,
    input  logic               ctrl_monitor,
    input  logic               addr_wr,
    input  logic [PAUSE_W-1:0] pause_len,
    input  logic               res_valid,
    input  logic               res_ack,
    input  logic               bus_tick,
    output logic               attempt_req,
    output logic               slave_ready
);
    smon_ctl_s ctl_d, ctl_q;
    logic      active;
    logic      gap_load;
    logic      gap_expired;

    assign active = ctrl_master & ctrl_monitor;

    smon_gap_timer #(.CNT_W(PAUSE_W)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (gap_load),
        .load_val_i (pause_len),
        .tick_i     (bus_tick),
        .expired_o  (gap_expired)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b0;
        gap_load    = 1'b0;
        if (!active) begin
            ctl_d.state = ST_IDLE;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE:    if (addr_wr) ctl_d.state = ST_ATTEMPT;
                ST_ATTEMPT: ctl_d.state = ST_WAIT;
                ST_WAIT: begin
                    if (res_valid) begin
                        if (res_ack) begin
                            ctl_d.state = ST_DONE;
                            ctl_d.ready = 1'b1;
                        end else begin
                            ctl_d.state = ST_PAUSE;
                            gap_load    = 1'b1;
                        end
                    end
                end
                ST_PAUSE:   if (bus_tick && gap_expired) ctl_d.state = ST_ATTEMPT;
                ST_DONE:    ctl_d.state = ST_DONE;
                default:    ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, ready: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign attempt_req = (ctl_q.state == ST_ATTEMPT);
    assign slave_ready = ctl_q.ready;

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        attempt_req |=> !attempt_req);

    // R4
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_ready |=> !slave_ready);

    // R8
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!attempt_req && !slave_ready));

    // R4
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_ready |-> ($past(res_valid) && $past(res_ack)));
endmodule

// File: tb/sim_smon_poll_seq.sv
module sim_smon_poll_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_master = 1'b0, ctrl_monitor = 1'b0, addr_wr = 1'b0;
    logic [3:0] pause_len = 4'd0;
    logic       res_valid = 1'b0, res_ack = 1'b0, bus_tick = 1'b0;
    logic       attempt_req, slave_ready;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    smon_poll_seq u0 (.*);

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic start_seq(input string tag);
        addr_wr = 1'b1; step(); addr_wr = 1'b0;
        check(attempt_req, 1'b1, {tag, " R3 request"});
        step();
        check(attempt_req, 1'b0, {tag, " R3 single"});
    endtask

    task automatic give_result(input logic ack);
        res_valid = 1'b1; res_ack = ack; step(); res_valid = 1'b0; res_ack = 1'b0;
    endtask

    task automatic ack_and_park(input string tag);
        give_result(1'b1);
        check(slave_ready, 1'b1, {tag, " R4 ready"});
        step();
        check(slave_ready, 1'b0, {tag, " R4 pulse"});
        ctrl_monitor = 1'b0; step(); ctrl_monitor = 1'b1;
    endtask

    task automatic t_reset();
        check(attempt_req, 1'b0, "R1 req");
        check(slave_ready, 1'b0, "R1 ready");
    endtask

    task automatic t_first_ack();
        ctrl_master = 1'b1; ctrl_monitor = 1'b1;
        start_seq("first");
        ack_and_park("first");
    endtask

    task automatic t_gap(input logic [3:0] p, input string tag);
        pause_len = p;
        start_seq(tag);
        give_result(1'b0);
        pause_len = 4'd0;
        for (int i = 0; i <= int'(p); i++) begin
            bus_tick = 1'b1; step(); bus_tick = 1'b0;
            if (i < int'(p)) begin
                check(attempt_req, 1'b0, {tag, " R5 early"});
                repeat (2) step();
                check(attempt_req, 1'b0, {tag, " R7 no tick"});
            end else begin
                check(attempt_req, 1'b1, {tag, " R5 retry"});
            end
        end
        step();
        ack_and_park(tag);
    endtask

    task automatic t_gated();
        ctrl_monitor = 1'b0; addr_wr = 1'b1; step(); addr_wr = 1'b0;
        check(attempt_req, 1'b0, "R2 monitor off");
        ctrl_monitor = 1'b1; ctrl_master = 1'b0;
        addr_wr = 1'b1; step(); addr_wr = 1'b0;
        check(attempt_req, 1'b0, "R2 master off");
        ctrl_master = 1'b1; step();
        check(attempt_req, 1'b0, "R2 stale strobe");
    endtask

    task automatic t_abort_wait();
        start_seq("abwait");
        ctrl_master = 1'b0; step(); ctrl_master = 1'b1;
        give_result(1'b1);
        check(slave_ready, 1'b0, "R8 late ack");
        step();
        check(attempt_req, 1'b0, "R8 no retry");
    endtask

    task automatic t_abort_pause();
        start_seq("abpause");
        give_result(1'b0);
        ctrl_monitor = 1'b0; step(); ctrl_monitor = 1'b1;
        for (int i = 0; i < 3; i++) begin
            bus_tick = 1'b1; step(); bus_tick = 1'b0;
            check(attempt_req, 1'b0, "R8 pause abort");
        end
    endtask

    task automatic t_parked();
        start_seq("park");
        give_result(1'b1);
        check(slave_ready, 1'b1, "R9 ready");
        addr_wr = 1'b1; bus_tick = 1'b1; step(); addr_wr = 1'b0; bus_tick = 1'b0;
        check(attempt_req, 1'b0, "R9 strobe ignored");
        give_result(1'b1);
        check(slave_ready, 1'b0, "R9 no second ready");
        ctrl_monitor = 1'b0; step(); ctrl_monitor = 1'b1;
        start_seq("R9 restart");
        ack_and_park("R9 restart");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1; step();
        t_reset();
        t_first_ack();
        t_gap(4'd0, "R6 p0");
        t_gap(4'd5, "p5");
        t_gap(4'd15, "R10 p15");
        t_gated();
        t_abort_wait();
        t_abort_pause();
        t_parked();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule